// File: doc/BRIEF.md
# Codirectional 64 kbit/s Transmit Encoder

This block takes one octet per 125 µs frame from a 2.048 Mbit/s serial PCM stream and sends it out as a 64 kbit/s codirectional line signal. The octet is collected during one of two time-slot windows, and a select input picks which one. The line signal leaves on two active-low rails, one for positive marks and one for negative marks, and it is paced by a 256 kHz unit-interval strobe.

Everything runs from one fast system clock. A strobe marks each PCM bit time and a second strobe marks each line unit interval. The two strobes are independent, so the PCM side and the line side can drift apart. A single holding latch between them absorbs up to one frame of that drift. When the drift goes further, the latch either repeats a whole octet or drops a whole octet, and it pulses a flag for each such event. An alarm input stops the octet-boundary violations from being inserted, so that a far end can see the alarm condition.

Top module: `cdx_tx_encoder`

## Requirements
- R1: On each cycle with `pcm_bit_en` high and the selected window high, `pcm_data` is sampled. Eight samples form one octet. The first sample becomes bit 0, and bit 0 is the first bit sent on the line.
- R2: With `slot_sel` high, only `slot_a_en` acts as the capture window. With `slot_sel` low, only `slot_b_en` does. The unselected window has no effect on the line output.
- R3: Each data bit lasts four unit intervals. A one uses the pattern 1,1,0,0 and a zero uses 1,0,1,0. A pattern value of 1 pulls low the rail of the current block polarity, and a 0 pulls low the other rail. The rails change only on a `line_ui_en` cycle.
- R4: The block polarity inverts at the start of every data bit, except as set out in R5. After reset, the first bit 0 has positive polarity.
- R5: With `alarm_in` low at the start of bit 7, bit 7 keeps the polarity of bit 6. This creates the octet-timing violation.
- R6: With `alarm_in` high at the start of bit 7, the polarity inverts as usual, so no violation is sent.
- R7: At each octet start, the line side takes the held octet if one is waiting. If none is waiting, it repeats its previous octet and pulses `ins_flag` high for one cycle.
- R8: If a new octet arrives while the held octet is still unread, the new octet replaces it and `del_flag` pulses high for one cycle.
- R9: If a new octet arrives in the same cycle that the line side reads a waiting octet, the reader takes the older octet, the new one is kept, and neither flag pulses.
- R10: During reset both rails are high (idle) and both flags are low. The latch starts empty. The first octet after reset is all ones and is flagged as a repeat.
- R11: Each flag rises in the cycle after the event that causes it.
- R12: If the selected window drops before eight samples, the partial octet is discarded and the bit count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pcm_bit_en | input | 1 | One-cycle strobe per 2.048 Mbit/s PCM bit |
| pcm_data | input | 1 | Serial PCM data |
| slot_a_en | input | 1 | Time-slot window A |
| slot_b_en | input | 1 | Time-slot window B |
| slot_sel | input | 1 | Window select: 1 = A, 0 = B |
| line_ui_en | input | 1 | One-cycle strobe per 256 kHz unit interval |
| alarm_in | input | 1 | Suppresses the octet violation while high |
| line_pos_n | output | 1 | Positive-mark rail, active low |
| line_neg_n | output | 1 | Negative-mark rail, active low |
| ins_flag | output | 1 | Octet-repeat pulse |
| del_flag | output | 1 | Octet-drop pulse |

## Verification
The bench runs the line side slower than the PCM side, which forces drops, and faster than it, which forces repeats. A buffer that mixed up the full state would then flag the wrong event or send stale data. It also switches the alarm input and the window select. A coder that toggled polarity on every bit, or that ignored the alarm, would give the wrong rail in bit 7. Truncated windows are driven as well. A capture counter that did not clear on a short window would assemble an octet from bits of two frames and shift every later octet.

// File: rtl/cdx_pkg.sv
package cdx_pkg;
  localparam int UI_PER_BIT = 4;
  typedef enum logic {POL_POS = 1'b0, POL_NEG = 1'b1} pol_e;
endpackage

// File: rtl/cdx_capture.sv
module cdx_capture #(
  parameter int OCT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             data,
  input  logic             win_a,
  input  logic             win_b,
  input  logic             sel,
  output logic             byte_vld,
  output logic [OCT_W-1:0] byte_q
);
  localparam int CW = (OCT_W > 1) ? $clog2(OCT_W) : 1;

  logic             win;
  logic [OCT_W-1:0] shreg;
  logic [OCT_W-1:0] shreg_nx;
  logic [CW-1:0]    cnt;

  assign win      = sel ? win_a : win_b;
  assign shreg_nx = {data, shreg[OCT_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      cnt      <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!win) begin
        cnt <= '0;
      end else if (bit_en) begin
        shreg <= shreg_nx;
        if (cnt == CW'(OCT_W-1)) begin
          cnt      <= '0;
          byte_vld <= 1'b1;
          byte_q   <= shreg_nx;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cdx_slip_buf.sv
module cdx_slip_buf #(
  parameter int             OCT_W      = 8,
  parameter logic [OCT_W-1:0] RESET_BYTE = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [OCT_W-1:0] wdata,
  input  logic             rd,
  output logic [OCT_W-1:0] hold_q,
  output logic             hold_full,
  output logic             ins_flag,
  output logic             del_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= RESET_BYTE;
      hold_full <= 1'b0;
      ins_flag  <= 1'b0;
      del_flag  <= 1'b0;
    end else begin
      ins_flag <= rd & ~hold_full;
      del_flag <= wr & hold_full & ~rd;
      if (wr) begin
        hold_q    <= wdata;
        hold_full <= 1'b1;
      end else if (rd) begin
        hold_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cdx_line_coder.sv
module cdx_line_coder
  import cdx_pkg::*;
#(
  parameter int             OCT_W      = 8,
  parameter logic [OCT_W-1:0] RESET_BYTE = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ui_en,
  input  logic             alarm,
  input  logic [OCT_W-1:0] hold_q,
  input  logic             hold_full,
  output logic             rd,
  output logic             pos_n,
  output logic             neg_n
);
  localparam int BW = (OCT_W > 1) ? $clog2(OCT_W) : 1;
  localparam int UW = $clog2(UI_PER_BIT);

  logic [UW-1:0]    ui_cnt, ui_nx;
  logic [BW-1:0]    bit_cnt, bit_nx;
  pol_e             pol, pol_nx;
  logic [OCT_W-1:0] oct, oct_nx;
  logic             last_ui, last_bit, dbit, pat, pos_act;

  assign last_ui  = (ui_cnt == UW'(UI_PER_BIT-1));
  assign last_bit = (bit_cnt == BW'(OCT_W-1));
  assign rd       = ui_en & last_ui & last_bit;

  always_comb begin
    ui_nx  = last_ui ? '0 : ui_cnt + 1'b1;
    bit_nx = bit_cnt;
    pol_nx = pol;
    if (last_ui) begin
      bit_nx = last_bit ? '0 : bit_cnt + 1'b1;
      if (bit_nx == BW'(OCT_W-1) && !alarm) pol_nx = pol;
      else pol_nx = (pol == POL_POS) ? POL_NEG : POL_POS;
    end
    oct_nx  = (rd && hold_full) ? hold_q : oct;
    dbit    = oct_nx[bit_nx];
    pat     = dbit ? (ui_nx < UW'(UI_PER_BIT/2)) : (ui_nx[0] == 1'b0);
    pos_act = pat ^ (pol_nx == POL_NEG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ui_cnt  <= UW'(UI_PER_BIT-1);
      bit_cnt <= BW'(OCT_W-1);
      pol     <= POL_NEG;
      oct     <= RESET_BYTE;
      pos_n   <= 1'b1;
      neg_n   <= 1'b1;
    end else if (ui_en) begin
      ui_cnt  <= ui_nx;
      bit_cnt <= bit_nx;
      pol     <= pol_nx;
      oct     <= oct_nx;
      pos_n   <= ~pos_act;
      neg_n   <= pos_act;
    end
  end
endmodule

// File: rtl/cdx_tx_encoder.sv
module cdx_tx_encoder #(
  parameter int             OCT_W      = 8,
  parameter logic [OCT_W-1:0] RESET_BYTE = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic pcm_bit_en,
  input  logic pcm_data,
  input  logic slot_a_en,
  input  logic slot_b_en,
  input  logic slot_sel,
  input  logic line_ui_en,
  input  logic alarm_in,
  output logic line_pos_n,
  output logic line_neg_n,
  output logic ins_flag,
  output logic del_flag
);
  logic             cap_vld;
  logic [OCT_W-1:0] cap_byte;
  logic [OCT_W-1:0] hold_q;
  logic             hold_full;
  logic             oct_rd;

  cdx_capture #(.OCT_W(OCT_W)) u_cap (
    .clk(clk), .rst(rst), .bit_en(pcm_bit_en), .data(pcm_data),
    .win_a(slot_a_en), .win_b(slot_b_en), .sel(slot_sel),
    .byte_vld(cap_vld), .byte_q(cap_byte)
  );

  cdx_slip_buf #(.OCT_W(OCT_W), .RESET_BYTE(RESET_BYTE)) u_buf (
    .clk(clk), .rst(rst), .wr(cap_vld), .wdata(cap_byte), .rd(oct_rd),
    .hold_q(hold_q), .hold_full(hold_full),
    .ins_flag(ins_flag), .del_flag(del_flag)
  );

  cdx_line_coder #(.OCT_W(OCT_W), .RESET_BYTE(RESET_BYTE)) u_coder (
    .clk(clk), .rst(rst), .ui_en(line_ui_en), .alarm(alarm_in),
    .hold_q(hold_q), .hold_full(hold_full), .rd(oct_rd),
    .pos_n(line_pos_n), .neg_n(line_neg_n)
  );
endmodule

// File: rtl/cdx_tx_encoder_chk.sv
module cdx_tx_encoder_chk (
  input logic clk,
  input logic rst,
  input logic line_ui_en,
  input logic cap_vld,
  input logic line_pos_n,
  input logic line_neg_n,
  input logic ins_flag,
  input logic del_flag
);
  // R3
  rail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_ui_en |=> $stable({line_pos_n, line_neg_n}));
  // R3
  single_rail_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~line_pos_n, ~line_neg_n}) <= 1);
  // R7
  ins_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ins_flag |=> !ins_flag);
  // R11
  ins_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ins_flag |-> $past(line_ui_en));
  // R8
  del_cause_chk: assert property (@(posedge clk) disable iff (rst)
    del_flag |-> $past(cap_vld));
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ins_flag && del_flag));
endmodule

bind cdx_tx_encoder cdx_tx_encoder_chk u_chk (
  .clk(clk), .rst(rst), .line_ui_en(line_ui_en), .cap_vld(cap_vld),
  .line_pos_n(line_pos_n), .line_neg_n(line_neg_n),
  .ins_flag(ins_flag), .del_flag(del_flag)
);

// File: tb/cdx_tx_encoder_test.sv
module cdx_tx_encoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pcm_bit_en = 0, pcm_data = 0, slot_a_en = 0, slot_b_en = 0;
  logic slot_sel = 1, line_ui_en = 0, alarm_in = 0;
  logic line_pos_n, line_neg_n, ins_flag, del_flag;

  int total = 0, bad = 0, n_ins = 0, n_del = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cdx_tx_encoder uut (
    .clk(clk), .rst(rst), .pcm_bit_en(pcm_bit_en), .pcm_data(pcm_data),
    .slot_a_en(slot_a_en), .slot_b_en(slot_b_en), .slot_sel(slot_sel),
    .line_ui_en(line_ui_en), .alarm_in(alarm_in),
    .line_pos_n(line_pos_n), .line_neg_n(line_neg_n),
    .ins_flag(ins_flag), .del_flag(del_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_ui, m_bit, m_cc;
  bit m_pol, m_full, m_pend, m_ins, m_del, e_pos, e_neg;
  bit [7:0] m_oct, m_hold, m_wbyte, m_cb;

  always @(posedge clk) begin
    if (rst) begin
      m_ui = 3; m_bit = 7; m_pol = 1; m_oct = 8'hFF; m_full = 0;
      m_pend = 0; m_cc = 0; m_ins = 0; m_del = 0; e_pos = 1; e_neg = 1;
    end else begin
      bit rd, wr, win, pat, pa;
      rd = line_ui_en && m_ui == 3 && m_bit == 7;
      wr = m_pend;
      m_ins = rd && !m_full;
      m_del = wr && m_full && !rd;
      if (rd && m_full) m_oct = m_hold;
      if (wr) begin m_hold = m_wbyte; m_full = 1; end
      else if (rd) m_full = 0;
      m_pend = 0;
      win = slot_sel ? slot_a_en : slot_b_en;
      if (!win) m_cc = 0;
      else if (pcm_bit_en) begin
        m_cb[m_cc] = pcm_data;
        m_cc++;
        if (m_cc == 8) begin m_cc = 0; m_pend = 1; m_wbyte = m_cb; end
      end
      if (line_ui_en) begin
        if (m_ui == 3) begin
          m_ui = 0;
          m_bit = (m_bit + 1) % 8;
          if (!(m_bit == 7 && !alarm_in)) m_pol = !m_pol;
        end else m_ui++;
        pat = m_oct[m_bit] ? (m_ui < 2) : (m_ui % 2 == 0);
        pa = pat ^ m_pol;
        e_pos = !pa; e_neg = pa;
      end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      // R10
      chk(line_pos_n && line_neg_n && !ins_flag && !del_flag, "R10 reset idle",
          {line_pos_n, line_neg_n, ins_flag, del_flag}, 4'b1100);
    end else if (!done) begin
      // R1 R2 R3 R4 R5 R6 R12 rails against model
      chk({line_pos_n, line_neg_n} == {e_pos, e_neg}, "R1 R2 R3 R4 R5 R6 R12 rails",
          {line_pos_n, line_neg_n}, {e_pos, e_neg});
      // R7 R10 R11 repeat flag
      chk(ins_flag == m_ins, "R7 R10 R11 ins_flag", ins_flag, m_ins);
      // R8 R9 R11 drop flag
      chk(del_flag == m_del, "R8 R9 R11 del_flag", del_flag, m_del);
      if (ins_flag) n_ins++;
      if (del_flag) n_del++;
    end
  end

  int fpos = 0, udiv = 0;

  task automatic run(input int frames, input int uper, input bit sel,
                     input bit alm, input int wlen);
    for (int c = 0; c < frames * 256; c++) begin
      @(negedge clk);
      slot_sel   = sel;
      alarm_in   = alm;
      pcm_bit_en = 1'b1;
      pcm_data   = 1'($urandom_range(0, 1));
      slot_a_en  = (fpos >= 8)  && (fpos < 8 + wlen);
      slot_b_en  = (fpos >= 40) && (fpos < 40 + wlen);
      fpos       = (fpos + 1) % 256;
      line_ui_en = (udiv == uper - 1);
      udiv       = line_ui_en ? 0 : udiv + 1;
    end
  endtask

  initial begin
    int i0, d0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    run(20, 8, 1, 0, 8);
    run(10, 8, 0, 0, 8);
    i0 = n_ins;
    run(20, 7, 1, 0, 8);
    // R7
    chk(n_ins > i0, "R7 fast line repeats", n_ins - i0, 1);
    d0 = n_del;
    run(20, 9, 0, 0, 8);
    // R8
    chk(n_del > d0, "R8 slow line drops", n_del - d0, 1);
    run(10, 8, 1, 1, 8);
    i0 = n_ins;
    run(6, 8, 1, 0, 5);
    // R12
    chk(n_ins - i0 >= 4, "R12 short window repeats", n_ins - i0, 4);
    run(6, 8, 0, 1, 8);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    done = 1;
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule